// File: doc/BRIEF.md
# SRAM Bus Cycle Timing Controller

This block sequences one access at a time to an asynchronous static RAM in a single chip-select area. A host presents a request with a direction, an address, write data and byte enables. The controller then drives chip select, the read strobe, one active-low write enable per byte lane, and an active-low direction line that marks writes. It returns a one-cycle ready pulse, and on reads it also returns the captured read data.

The controller runs on a phase clock at twice the bus rate, so one bus cycle is two phases. Every strobe edge falls on a phase boundary, and this gives half-cycle resolution for the setup delay. A small configuration register sets the timing: a read wait count, a write wait count, an address-to-strobe setup delay and a byte-select mode. The byte-select mode chooses which signal spans the whole access. In one mode the direction line spans it and the write enables act as the strobe. In the other mode the write enables act as lane selects for the whole access and the direction line is the strobe. The sequencer latches the timing when it accepts a request, so a register write never disturbs an access already in progress.

Top module: `sram_tmg_ctrl`

## Requirements
- R1: After reset, `sram_cs_n`, `sram_rd_n` and `sram_dir_n` are 1, every bit of `sram_we_n` is 1, `ack` is 0 and `cfg_rdata` reads 0.
- R2: The configuration fields are read wait in bits 3:0, write wait in bits 6:4, setup in bits 9:8 and byte-select mode in bit 12. The other bits always read 0, so writing 16'hFFFF reads back as 16'h137F.
- R3: `sram_cs_n` goes low in the first phase after the clock edge that accepts a request. The strobe (read strobe or write strobe) first asserts after 2*setup+1 phases, which is 0.5, 1.5, 2.5 or 3.5 bus cycles for setup codes 0 to 3.
- R4: A read strobe stays low for 2*(read_wait+1) phases.
- R5: Write-wait codes 1 to 7 give code-1 wait cycles, and code 0 uses the read-wait value. The write strobe lasts 2*(wait+1) phases.
- R6: With byte-select mode 0, the write strobe is `sram_we_n`. The enabled lanes (bit n of `sram_we_n` low when `req_be[n]` is 1) go low only in the strobe window, and `sram_dir_n` stays low for the whole chip-select window of a write. On reads, `sram_we_n` and `sram_dir_n` stay high.
- R7: With byte-select mode 1, the enabled lanes of `sram_we_n` stay low for the whole chip-select window on both reads and writes. On writes `sram_dir_n` is the strobe and stays low only in the strobe window.
- R8: After the strobe negates, chip select stays low for 2 more phases. `ack` is high for exactly one cycle, in the first phase in which `sram_cs_n` is high again.
- R9: On a read, `rdata` holds the value present on `sram_rdata` during the last phase of the read strobe, and it is valid while `ack` is high.
- R10: A configuration write made during an access takes effect only from the next accepted request.
- R11: A request is accepted only when the controller is idle, and a request raised during an access is dropped.
- R12: While chip select is low, `sram_addr` equals the accepted address. During a write strobe, `sram_wdata` equals the accepted write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read-back value |
| req | input | 1 | Access request, taken when idle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte lane enables |
| ack | output | 1 | One-cycle ready pulse at end of access |
| rdata | output | DW | Captured read data |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_rd_n | output | 1 | Read strobe, active low |
| sram_we_n | output | DW/8 | Per-lane write enables, active low |
| sram_dir_n | output | 1 | Direction, low marks a write |
| sram_addr | output | AW | SRAM address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data |

## Verification
With S = 2*setup+1 and T = 2*(wait+1), chip select is due in the first phase after the accepting edge. The strobe is due in phase S+1 and lasts T phases, and `ack` and the read data are due in phase S+T+3. The bench drives inputs on the falling edge and numbers each falling-edge sample from the accepting edge. It then compares the first strobe phase, the strobe width, the chip-select width and the ack phase exactly against these formulas. Its SRAM model presents valid read data only in the last strobe phase, so a capture one phase early or late shows up as wrong data.

// File: rtl/sram_tmg_pkg.sv
package sram_tmg_pkg;

    localparam int CFG_W   = 16;
    localparam int RW_W    = 4;
    localparam int WW_W    = 3;
    localparam int SU_W    = 2;
    localparam int RW_LSB  = 0;
    localparam int WW_LSB  = 4;
    localparam int SU_LSB  = 8;
    localparam int BS_BIT  = 12;
    localparam int CNT_W   = RW_W + 1;

    localparam logic [CFG_W-1:0] CFG_MASK =
        CFG_W'(((1 << RW_W) - 1) << RW_LSB) |
        CFG_W'(((1 << WW_W) - 1) << WW_LSB) |
        CFG_W'(((1 << SU_W) - 1) << SU_LSB) |
        CFG_W'(1 << BS_BIT);

    typedef struct packed {
        logic [RW_W-1:0] rwait;
        logic [WW_W-1:0] wwait;
        logic [SU_W-1:0] setup;
        logic            bsel;
    } tmg_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } seq_state_t;

    function automatic tmg_cfg_t cfg_unpack(input logic [CFG_W-1:0] r);
        tmg_cfg_t c;
        c.rwait = r[RW_LSB +: RW_W];
        c.wwait = r[WW_LSB +: WW_W];
        c.setup = r[SU_LSB +: SU_W];
        c.bsel  = r[BS_BIT];
        return c;
    endfunction

endpackage

// File: rtl/sram_tmg_cfg.sv
module sram_tmg_cfg
    import sram_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output tmg_cfg_t         cfg
);

    logic [CFG_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (cfg_we) begin
            reg_d = cfg_wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign cfg_rdata = reg_q;
    assign cfg       = cfg_unpack(reg_q);

endmodule

// File: rtl/sram_tmg_seq.sv
module sram_tmg_seq
    import sram_tmg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmg_cfg_t      cfg,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_be,
    input  logic [DW-1:0] sram_rdata,
    output seq_state_t    state,
    output logic          acc_wr,
    output logic          acc_bsel,
    output logic [NB-1:0] acc_be,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rdata,
    output logic          ack
);

    typedef struct packed {
        seq_state_t      state;
        logic [CNT_W-1:0] cnt;
        logic            wr;
        logic            bsel;
        logic [RW_W-1:0] wt;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [NB-1:0]   be;
        logic [DW-1:0]   rdata;
        logic            ack;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic [RW_W-1:0] wt_sel;

    always_comb begin
        if (!req_wr)                wt_sel = cfg.rwait;
        else if (cfg.wwait == '0)   wt_sel = cfg.rwait;
        else                        wt_sel = RW_W'(cfg.wwait - WW_W'(1));
    end

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req) begin
                    s_d.state = ST_SETUP;
                    s_d.cnt   = CNT_W'({cfg.setup, 1'b0});
                    s_d.wr    = req_wr;
                    s_d.bsel  = cfg.bsel;
                    s_d.wt    = wt_sel;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.be    = req_be;
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_STROBE;
                    s_d.cnt   = {s_q.wt, 1'b1};
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_HOLD;
                    s_d.cnt   = CNT_W'(1);
                    if (!s_q.wr) s_d.rdata = sram_rdata;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_DONE;
                    s_d.ack   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state     = s_q.state;
    assign acc_wr    = s_q.wr;
    assign acc_bsel  = s_q.bsel;
    assign acc_be    = s_q.be;
    assign acc_addr  = s_q.addr;
    assign acc_wdata = s_q.wdata;
    assign rdata     = s_q.rdata;
    assign ack       = s_q.ack;

endmodule

// File: rtl/sram_tmg_pins.sv
module sram_tmg_pins
    import sram_tmg_pkg::*;
#(
    parameter int NB = 4
) (
    input  seq_state_t    state,
    input  logic          acc_wr,
    input  logic          acc_bsel,
    input  logic [NB-1:0] acc_be,
    output logic          sram_cs_n,
    output logic          sram_rd_n,
    output logic [NB-1:0] sram_we_n,
    output logic          sram_dir_n
);

    logic in_cs, in_stb;

    always_comb begin
        in_cs     = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        in_stb    = (state == ST_STROBE);
        sram_cs_n = !in_cs;
        sram_rd_n = !(in_stb && !acc_wr);
        if (acc_bsel) begin
            sram_we_n  = ~(acc_be & {NB{in_cs}});
            sram_dir_n = !(in_stb && acc_wr);
        end else begin
            sram_we_n  = ~(acc_be & {NB{in_stb && acc_wr}});
            sram_dir_n = !(in_cs && acc_wr);
        end
    end

endmodule

// File: rtl/sram_tmg_ctrl.sv
module sram_tmg_ctrl
    import sram_tmg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             req,
    input  logic             req_wr,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [NB-1:0]    req_be,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    output logic             sram_cs_n,
    output logic             sram_rd_n,
    output logic [NB-1:0]    sram_we_n,
    output logic             sram_dir_n,
    output logic [AW-1:0]    sram_addr,
    output logic [DW-1:0]    sram_wdata,
    input  logic [DW-1:0]    sram_rdata
);

    tmg_cfg_t      cfg;
    seq_state_t    state;
    logic          acc_wr, acc_bsel;
    logic [NB-1:0] acc_be;

    sram_tmg_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    sram_tmg_seq #(.AW(AW), .DW(DW), .NB(NB)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .req        (req),
        .req_wr     (req_wr),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .sram_rdata (sram_rdata),
        .state      (state),
        .acc_wr     (acc_wr),
        .acc_bsel   (acc_bsel),
        .acc_be     (acc_be),
        .acc_addr   (sram_addr),
        .acc_wdata  (sram_wdata),
        .rdata      (rdata),
        .ack        (ack)
    );

    sram_tmg_pins #(.NB(NB)) u_pins (
        .state      (state),
        .acc_wr     (acc_wr),
        .acc_bsel   (acc_bsel),
        .acc_be     (acc_be),
        .sram_cs_n  (sram_cs_n),
        .sram_rd_n  (sram_rd_n),
        .sram_we_n  (sram_we_n),
        .sram_dir_n (sram_dir_n)
    );

endmodule

// File: rtl/sram_tmg_chk.sv
module sram_tmg_chk
    import sram_tmg_pkg::*;
#(
    parameter int AW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             sram_cs_n,
    input logic             sram_rd_n,
    input logic             sram_dir_n,
    input logic [AW-1:0]    sram_addr,
    input logic [CFG_W-1:0] cfg_rdata
);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8

    AST_ACK_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $rose(sram_cs_n)); // R8

    AST_RD_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_rd_n |-> !sram_cs_n); // R3

    AST_CS_FALL_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_cs_n) |-> sram_rd_n); // R3

    AST_RD_NOT_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_rd_n |-> sram_dir_n); // R6

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr)); // R12

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~CFG_MASK) == '0); // R2

endmodule

bind sram_tmg_ctrl sram_tmg_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .sram_cs_n  (sram_cs_n),
    .sram_rd_n  (sram_rd_n),
    .sram_dir_n (sram_dir_n),
    .sram_addr  (sram_addr),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/tb_sram_tmg_ctrl.sv
module tb_sram_tmg_ctrl;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_be = '0;
    logic          ack;
    logic [DW-1:0] rdata;
    logic          sram_cs_n, sram_rd_n, sram_dir_n;
    logic [NB-1:0] sram_we_n;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata;
    logic [DW-1:0] sram_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_t   = 2;
    int rd_cnt  = 0;

    always #2 clk = ~clk;

    sram_tmg_ctrl #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
        .sram_cs_n(sram_cs_n), .sram_rd_n(sram_rd_n), .sram_we_n(sram_we_n),
        .sram_dir_n(sram_dir_n), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata)
    );

    // SRAM model: data is valid only in the last phase of the read strobe
    always @(posedge clk) begin
        if (sram_rd_n) rd_cnt <= 0;
        else           rd_cnt <= rd_cnt + 1;
    end
    assign sram_rdata = (!sram_rd_n && rd_cnt == exp_t - 1) ? {~sram_addr, sram_addr}
                                                            : 32'hDEAD_BEEF;

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] mk_cfg(input logic [3:0] rw, input logic [2:0] ww,
                                           input logic [1:0] su, input logic bs);
        return {3'b0, bs, 2'b0, su, 1'b0, ww, rw};
    endfunction

    task automatic run_access(input logic wr, input logic [AW-1:0] addr,
                              input logic [NB-1:0] be, input logic bs,
                              input int s_exp, input int t_exp,
                              input logic inj_cfg, input logic [15:0] inj_val,
                              input logic inj_req);
        int cs_cnt = 0, stb_cnt = 0, first_stb = 0, held_cnt = 0;
        int ack_cnt = 0, ack_idx = 0, bad_lane = 0, bad_addr = 0, bad_data = 0;
        int held_exp;
        logic stb, held;
        logic [DW-1:0] wdata = {addr, ~addr};
        logic [DW-1:0] got = '0;
        string stag = wr ? "R5" : "R4";
        string mtag = bs ? "R7" : "R6";
        exp_t = t_exp;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = addr; req_wdata = wdata; req_be = be;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (!sram_cs_n) cs_cnt++;
            stb = wr ? (bs ? !sram_dir_n : (sram_we_n != '1)) : !sram_rd_n;
            if (stb) begin
                stb_cnt++;
                if (first_stb == 0) first_stb = k;
                if (wr && sram_wdata !== wdata) bad_data++;
            end
            held = bs ? (sram_we_n == ~be) : (wr && !sram_dir_n);
            if (held) held_cnt++;
            if (!wr && !sram_dir_n) bad_lane++;
            if (!wr && !bs && sram_we_n != '1) bad_lane++;
            if (!bs && wr && sram_we_n != '1 && sram_we_n != ~be) bad_lane++;
            if (!sram_cs_n && sram_addr !== addr) bad_addr++;
            if (ack) begin ack_cnt++; ack_idx = k; got = rdata; end
            if (k == 1) req = 1'b0;
            if (inj_cfg && k == 2) begin cfg_we = 1'b1; cfg_wdata = inj_val; end
            if (inj_cfg && k == 3) cfg_we = 1'b0;
            if (inj_req && k == 3) begin req = 1'b1; req_addr = ~addr; end
            if (inj_req && k == 4) req = 1'b0;
        end
        held_exp = (bs || wr) ? s_exp + t_exp + 2 : 0;
        check(first_stb == s_exp + 1, "R3 strobe start phase", first_stb, s_exp + 1);
        check(stb_cnt == t_exp, {stag, " strobe width"}, stb_cnt, t_exp);
        check(held_cnt == held_exp, {mtag, " held signal width"}, held_cnt, held_exp);
        check(bad_lane == 0, {mtag, " lane/direction pattern"}, bad_lane, 0);
        check(cs_cnt == s_exp + t_exp + 2, "R8 chip select width", cs_cnt, s_exp + t_exp + 2);
        check(ack_cnt == 1 && ack_idx == s_exp + t_exp + 3, "R8 ack phase",
              ack_idx, s_exp + t_exp + 3);
        check(bad_addr == 0 && bad_data == 0, "R12 address/data stable",
              bad_addr + bad_data, 0);
        if (!wr) check(got == {~addr, addr}, "R9 read data", got, {~addr, addr});
        if (inj_req) check(bad_addr == 0 && ack_cnt == 1, "R11 busy request dropped",
                           ack_cnt, 1);
    endtask

    typedef struct packed {
        logic [3:0]  rw;
        logic [2:0]  ww;
        logic [1:0]  su;
        logic        bs;
        logic        wr;
        logic [3:0]  be;
        logic [15:0] addr;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{4'd0,  3'd1, 2'd0, 1'b0, 1'b0, 4'hF, 16'h0010},
        '{4'd3,  3'd0, 2'd1, 1'b0, 1'b1, 4'h3, 16'h1234},
        '{4'd2,  3'd7, 2'd3, 1'b0, 1'b1, 4'h5, 16'h8001},
        '{4'd15, 3'd2, 2'd2, 1'b0, 1'b0, 4'hF, 16'h4321},
        '{4'd1,  3'd4, 2'd0, 1'b1, 1'b1, 4'hA, 16'h00FF},
        '{4'd5,  3'd0, 2'd3, 1'b1, 1'b1, 4'hF, 16'hBEEF},
        '{4'd4,  3'd1, 2'd1, 1'b1, 1'b0, 4'h6, 16'h5A5A},
        '{4'd0,  3'd1, 2'd0, 1'b1, 1'b1, 4'h1, 16'h7777}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sram_cs_n && sram_rd_n && sram_dir_n, "R1 strobes idle high",
              {sram_cs_n, sram_rd_n, sram_dir_n}, 3'b111);
        check(sram_we_n == '1 && !ack, "R1 write enables and ack", {sram_we_n, ack}, 5'b11110);
        check(cfg_rdata == 16'h0, "R1 config reset", cfg_rdata, 16'h0);

        // R2 read-back masking
        write_cfg(16'hFFFF);
        check(cfg_rdata == 16'h137F, "R2 reserved bits read 0", cfg_rdata, 16'h137F);
        write_cfg(16'h0213);
        check(cfg_rdata == 16'h0213, "R2 field read-back", cfg_rdata, 16'h0213);

        // table walk
        foreach (VECS[i]) begin
            int w, s, t;
            write_cfg(mk_cfg(VECS[i].rw, VECS[i].ww, VECS[i].su, VECS[i].bs));
            if (!VECS[i].wr || VECS[i].ww == 3'd0) w = VECS[i].rw;
            else                                   w = VECS[i].ww - 1;
            s = 2 * VECS[i].su + 1;
            t = 2 * (w + 1);
            run_access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].bs, s, t,
                       1'b0, 16'h0, 1'b0);
        end

        // R10 configuration change during an access, plus R11 busy request
        write_cfg(mk_cfg(4'd2, 3'd1, 2'd0, 1'b0));
        run_access(1'b0, 16'h0A0A, 4'hF, 1'b0, 1, 6, 1'b1,
                   mk_cfg(4'd6, 3'd1, 2'd0, 1'b0), 1'b1);
        run_access(1'b0, 16'h0B0B, 4'hF, 1'b0, 1, 14, 1'b0, 16'h0, 1'b0);
        check(cfg_rdata == mk_cfg(4'd6, 3'd1, 2'd0, 1'b0), "R10 new config applied",
              cfg_rdata, mk_cfg(4'd6, 3'd1, 2'd0, 1'b0));

        // R11 idle after dropped request
        begin
            int busy = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (!sram_cs_n || ack) busy++;
            end
            check(busy == 0, "R11 no access started", busy, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule